// File: doc/BRIEF.md
# Int8 Tile Dot-Product Accumulator

This block multiplies two small integer matrices held in local register tiles and adds the product into a third tile, in place. Every 32-bit word of the A and B tiles carries four packed bytes. For each output word the block forms four byte products between a word of an A row and a word of a B column, adds them together, and adds that sum into the 32-bit output word. The output tile C is therefore both the accumulator source and the destination of the operation.

A host fills A, B and optionally C through one word-wide write port, picks one of four byte-signedness modes, and pulses start. The block then works through one output word per k step and raises a single-cycle done once it has finished. A clear command zeroes C, and a combinational read port returns any word of C.

Top module: `int8_tile_dot`

## Requirements
- R1: After an operation, every C[m][n] equals its previous value plus the sum over k = 0..K-1 and byte i = 0..3 of byteA(A[m][k], i) times byteB(B[k][n], i). Byte i of a word sits in bits 8i+7 down to 8i.
- R2: `mode[1]` = 1 makes the A bytes signed (two's complement) and 0 makes them unsigned. `mode[0]` does the same for the B bytes. The mode is captured when start is accepted, and changing it later has no effect on that operation.
- R3: Accumulation wraps modulo 2^32 and raises no flag.
- R4: With K = 16, every A byte at -1 and every B byte at -2 in mode 2'b11 give 128 in every C word starting from zero. With every A byte at -1 and every B byte at +2 in mode 2'b10 the result is -128 everywhere.
- R5: When the block is idle, a `clr_c` pulse sets every C word to zero. If `clr_c` and `start` arrive in the same cycle, the clear happens first and the result is A·B alone.
- R6: `busy` rises in the cycle after start is accepted and stays high for exactly M·N·K cycles. `done` is high for one cycle, which is the first cycle with `busy` low.
- R7: A start that arrives while `busy` is high is ignored. It neither restarts nor lengthens the operation.
- R8: While `busy` is high, tile writes and `clr_c` are ignored.
- R9: After reset, `busy` and `done` are low and every C word reads zero.
- R10: A write with `wr_en` high stores `wr_data` at word (`wr_row`, `wr_col`) of the tile chosen by `wr_sel`: 0 selects A, 1 selects B, 2 selects C, and 3 selects nothing. `rd_data` returns C[`rd_row`][`rd_col`] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Byte signedness: bit 1 for A, bit 0 for B, 1 = signed |
| start | input | 1 | Begin an operation when idle |
| clr_c | input | 1 | Zero the C tile when idle |
| wr_en | input | 1 | Tile write strobe |
| wr_sel | input | 2 | Tile select: 0 = A, 1 = B, 2 = C, 3 = none |
| wr_row | input | IW | Word row of the write |
| wr_col | input | IW | Word column of the write |
| wr_data | input | 32 | Write data |
| rd_row | input | IW | Word row of the C read |
| rd_col | input | IW | Word column of the C read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | C word at (rd_row, rd_col) |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is a clear command and a start, both presented in the same cycle while the block is idle. The bench drives them together onto a C tile that still holds the previous result, and it accepts the outcome only if C equals A·B with no trace of the old values. The second pair is a start, a clear and a C write that all arrive in the middle of a running operation, while the mode input is switched at the same time. There the bench requires the run to keep its length of M·N·K cycles, to give a single done pulse, and to produce a result that matches a model using the mode captured at start, with no clear and no write applied.

// File: rtl/int8tile_pkg.sv
// Package: shared constants for the int8 tile dot-product block.
// Assumes 32-bit words made of four 8-bit lanes.
package int8tile_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } tile_sel_e;
endpackage

// File: rtl/int8tile_dot4.sv
// Module: four-lane byte multiply and sum.
// Each lane is widened to 9 bits, with the top bit taken from the sign
// when that operand is signed and forced to zero when it is unsigned.
// The four products are summed and sign-extended to one word.
// Assumes: purely combinational; the caller does the accumulate.
module int8tile_dot4
    import int8tile_pkg::*;
(
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [WORD_W-1:0] sum
);
    localparam int PROD_W = 2 * (BYTE_W + 1);
    localparam int SUM_W  = PROD_W + $clog2(LANES);

    logic signed [PROD_W-1:0] prod [LANES];
    logic signed [SUM_W-1:0]  total;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [BYTE_W:0] ax;
        logic signed [BYTE_W:0] bx;
        assign ax      = {a_signed & a_word[BYTE_W*g+BYTE_W-1], a_word[BYTE_W*g +: BYTE_W]};
        assign bx      = {b_signed & b_word[BYTE_W*g+BYTE_W-1], b_word[BYTE_W*g +: BYTE_W]};
        assign prod[g] = ax * bx;
    end

    // Add the lane products into a single signed sum.
    always_comb begin
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            total = total + SUM_W'(prod[i]);
        end
    end

    assign sum = {{(WORD_W-SUM_W){total[SUM_W-1]}}, total};

    // When both operands are unsigned, the sum can never be negative.
    always_comb begin
        if (!a_signed && !b_signed) begin
            a_r2_unsigned_nonneg: assert (total[SUM_W-1] == 1'b0);
        end
    end
endmodule

// File: rtl/int8tile_seq.sv
// Module: operation sequencer. It walks m, n and k with k innermost and
// produces one accumulate step per busy cycle.
// Assumes: start is honoured only while idle.
module int8tile_seq #(
    parameter int M  = 16,
    parameter int N  = 16,
    parameter int K  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] m_idx,
    output logic [IW-1:0] n_idx,
    output logic [IW-1:0] k_idx
);
    localparam int TOTAL = M * N * K;
    localparam int CW    = $clog2(TOTAL + 1);

    logic k_last, n_last, m_last;
    assign k_last = (k_idx == IW'(K - 1));
    assign n_last = (n_idx == IW'(N - 1));
    assign m_last = (m_idx == IW'(M - 1));

    // Advance the nested counters, and end the run with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            m_idx <= '0;
            n_idx <= '0;
            k_idx <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (!k_last) begin
                    k_idx <= k_idx + 1'b1;
                end else begin
                    k_idx <= '0;
                    if (!n_last) begin
                        n_idx <= n_idx + 1'b1;
                    end else begin
                        n_idx <= '0;
                        if (!m_last) begin
                            m_idx <= m_idx + 1'b1;
                        end else begin
                            m_idx <= '0;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                        end
                    end
                end
            end else if (start) begin
                busy  <= 1'b1;
                m_idx <= '0;
                n_idx <= '0;
                k_idx <= '0;
            end
        end
    end

    // Checker counter that measures the length of each run.
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r6_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(TOTAL)));
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(k_last && n_last && m_last)) |=> (busy && !done));
endmodule

// File: rtl/int8_tile_dot.sv
// Module: int8 tile dot-product accumulator (top).
// It holds the A (M x K words), B (K x N words) and C (M x N words) tiles
// in register arrays, and on each busy cycle it adds the four-lane byte dot
// product of A[m][k] and B[k][n] into C[m][n].
// Assumes: tiles are loaded only while idle; C is read combinationally.
module int8_tile_dot
    import int8tile_pkg::*;
#(
    parameter int M  = 16,
    parameter int N  = 16,
    parameter int K  = 16,
    parameter int IW = $clog2((M > N ? (M > K ? M : K) : (N > K ? N : K)))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              start,
    input  logic              clr_c,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IW-1:0]     wr_row,
    input  logic [IW-1:0]     wr_col,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IW-1:0]     rd_row,
    input  logic [IW-1:0]     rd_col,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data
);
    localparam int SPAN = 1 << IW;

    logic [WORD_W-1:0] a_mem [SPAN][SPAN];
    logic [WORD_W-1:0] b_mem [SPAN][SPAN];
    logic [WORD_W-1:0] c_mem [SPAN][SPAN];

    logic [IW-1:0]     m_idx, n_idx, k_idx;
    logic [1:0]        mode_q;
    logic [WORD_W-1:0] step_sum;
    logic              host_ok;

    int8tile_seq #(.M(M), .N(N), .K(K), .IW(IW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .m_idx (m_idx),
        .n_idx (n_idx),
        .k_idx (k_idx)
    );

    int8tile_dot4 u_dot4 (
        .a_word   (a_mem[m_idx][k_idx]),
        .b_word   (b_mem[k_idx][n_idx]),
        .a_signed (mode_q[1]),
        .b_signed (mode_q[0]),
        .sum      (step_sum)
    );

    assign host_ok = wr_en && !busy;

    // Capture the signedness mode when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_q <= 2'b00;
        else if (start && !busy) mode_q <= mode;
    end

    // Host writes into the A tile, within its M x K bounds.
    always_ff @(posedge clk) begin
        if (host_ok && wr_sel == SEL_A && int'(wr_row) < M && int'(wr_col) < K)
            a_mem[wr_row][wr_col] <= wr_data;
    end

    // Host writes into the B tile, within its K x N bounds.
    always_ff @(posedge clk) begin
        if (host_ok && wr_sel == SEL_B && int'(wr_row) < K && int'(wr_col) < N)
            b_mem[wr_row][wr_col] <= wr_data;
    end

    // C tile: reset, in-place accumulate, clear, then host write, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < SPAN; r++)
                for (int c = 0; c < SPAN; c++)
                    c_mem[r][c] <= '0;
        end else if (busy) begin
            c_mem[m_idx][n_idx] <= c_mem[m_idx][n_idx] + step_sum;
        end else if (clr_c) begin
            for (int r = 0; r < SPAN; r++)
                for (int c = 0; c < SPAN; c++)
                    c_mem[r][c] <= '0;
        end else if (wr_en && wr_sel == SEL_C && int'(wr_row) < M && int'(wr_col) < N) begin
            c_mem[wr_row][wr_col] <= wr_data;
        end
    end

    assign rd_data = c_mem[rd_row][rd_col];

    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));
    a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !busy) |=> (c_mem[0][0] == '0 && c_mem[M-1][N-1] == '0));
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(m_idx == '0 && n_idx == '0)) |=> $stable(c_mem[0][0]));
endmodule

// File: tb/sim_int8_tile_dot.sv
// Bench: seeded random tiles mixed with directed corner cases, checked
// against a behavioural model held in the bench.
module sim_int8_tile_dot;
    localparam int CLK_PERIOD = 10;
    localparam int M = 16, N = 16, K = 16, IW = 4;
    localparam int OP_LEN = M * N * K;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] mode = 2'b00, wr_sel = 2'd3;
    logic start = 1'b0, clr_c = 1'b0, wr_en = 1'b0;
    logic [IW-1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
    logic [31:0] wr_data = '0;
    logic busy, done;
    logic [31:0] rd_data;

    int n_checks = 0, n_errors = 0;
    int ma [M][K];
    int mb [K][N];
    int mc [M][N];

    always #(CLK_PERIOD/2) clk = ~clk;

    int8_tile_dot #(.M(M), .N(N), .K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .clr_c(clr_c),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .rd_row(rd_row), .rd_col(rd_col),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int lane(input int w, input int i, input bit sgn);
        int v;
        v = (w >> (8 * i)) & 255;
        if (sgn && v >= 128) v = v - 256;
        return v;
    endfunction

    function automatic int dot4(input int a, input int b, input bit sa, input bit sb);
        int s = 0;
        for (int i = 0; i < 4; i++) s += lane(a, i, sa) * lane(b, i, sb);
        return s;
    endfunction

    task automatic write_word(input logic [1:0] sel, input int r, input int c, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_row = IW'(r); wr_col = IW'(c); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic load_tiles(input bit with_c);
        for (int r = 0; r < M; r++) for (int c = 0; c < K; c++) write_word(2'd0, r, c, ma[r][c]);
        for (int r = 0; r < K; r++) for (int c = 0; c < N; c++) write_word(2'd1, r, c, mb[r][c]);
        if (with_c)
            for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) write_word(2'd2, r, c, mc[r][c]);
    endtask

    // Compare every C word with the model (rd_data is combinational).
    task automatic check_c(input string req);
        for (int r = 0; r < M; r++) begin
            for (int c = 0; c < N; c++) begin
                rd_row = IW'(r); rd_col = IW'(c);
                #1;
                check(req, rd_data, mc[r][c]);
            end
        end
    endtask

    // Start one run, optionally with a clear in the same cycle and
    // optionally with disturbances injected while busy; then update the model.
    task automatic run_op(input logic [1:0] md, input bit with_clr, input bit inject);
        int cnt = 0, dones = 0, guard = 0;
        @(negedge clk);
        mode = md; start = 1'b1; clr_c = with_clr;
        @(negedge clk);
        start = 1'b0; clr_c = 1'b0;
        while (busy && guard < OP_LEN + 100) begin
            cnt++; guard++;
            if (done) dones++;
            if (inject && cnt == 100) begin
                start = 1'b1; clr_c = 1'b1; wr_en = 1'b1; wr_sel = 2'd2;
                wr_row = '0; wr_col = '0; wr_data = 32'h0000_DEAD; mode = ~md;
            end else if (inject && cnt == 101) begin
                start = 1'b0; clr_c = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
            end
            @(negedge clk);
        end
        check("R6 busy length", cnt, OP_LEN);
        check("R6 done at end", int'(done), 1);
        check("R7 no done while busy", dones, 0);
        @(negedge clk);
        check("R6 done one cycle", int'(done), 0);
        check("R7 no restart", int'(busy), 0);
        if (with_clr) for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) mc[r][c] = 0;
        for (int r = 0; r < M; r++)
            for (int c = 0; c < N; c++)
                for (int k = 0; k < K; k++)
                    mc[r][c] += dot4(ma[r][k], mb[k][c], md[1], md[0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 busy", int'(busy), 0);
        check("R9 done", int'(done), 0);
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) mc[r][c] = 0;
        check_c("R9 C zero");

        // R4: signed x signed, -1 * -2 over K words gives 128
        for (int r = 0; r < M; r++) for (int c = 0; c < K; c++) begin
            ma[r][c] = 32'hFFFF_FFFF; mb[c][r] = 32'hFEFE_FEFE;
        end
        load_tiles(1'b0);
        run_op(2'b11, 1'b0, 1'b0);
        check("R4 ss corner", mc[5][7], 128);
        check_c("R4 ss 128");

        // R4 and R5: signed x unsigned, with the clear in the start cycle, gives -128
        for (int r = 0; r < K; r++) for (int c = 0; c < N; c++) mb[r][c] = 32'h0202_0202;
        load_tiles(1'b0);
        run_op(2'b10, 1'b1, 1'b0);
        check("R4 su corner", mc[0][0], -128);
        check_c("R5 clear+start su -128");

        // R1, R2, R7 and R8: random unsigned x unsigned with disturbances while busy
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) begin
            ma[r][c] = int'($urandom); mb[r][c] = int'($urandom); mc[r][c] = int'($urandom);
        end
        load_tiles(1'b1);
        run_op(2'b00, 1'b0, 1'b1);
        check_c("R8 R2 uu injected");

        // R1 and R10: unsigned x signed, accumulating onto the previous C
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) begin
            ma[r][c] = int'($urandom); mb[r][c] = int'($urandom);
        end
        load_tiles(1'b0);
        run_op(2'b01, 1'b0, 1'b0);
        check_c("R1 us accumulate");

        // R3: unsigned maximum bytes wrap past 2^32
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) begin
            ma[r][c] = 32'hFFFF_FFFF; mb[r][c] = 32'hFFFF_FFFF; mc[r][c] = 32'hFFF0_0000;
        end
        load_tiles(1'b1);
        run_op(2'b00, 1'b0, 1'b0);
        check("R3 wrap value", mc[2][3], 32'hFFF0_0000 + 16 * 260100);
        check_c("R3 wrap");

        // R10: single C write and read back; R5: clear while idle
        write_word(2'd2, 3, 5, 32'h1234_5678);
        mc[3][5] = 32'h1234_5678;
        rd_row = 4'd3; rd_col = 4'd5; #1;
        check("R10 C write readback", rd_data, 32'h1234_5678);
        write_word(2'd3, 3, 5, 32'h0BAD_0BAD);
        rd_row = 4'd3; rd_col = 4'd5; #1;
        check("R10 select none", rd_data, 32'h1234_5678);
        @(negedge clk); clr_c = 1'b1;
        @(negedge clk); clr_c = 1'b0;
        for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) mc[r][c] = 0;
        check_c("R5 clear idle");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule